// File: doc/BRIEF.md
# Display Transmitter Configuration Target with DDC Switch Handshake

This block is the I2C target side of a display transmitter's configuration port. It recognises START and STOP conditions, matches its own 7-bit address, acknowledges the bytes it receives and shifts out read data. Behind that bit logic sits an 8-bit register pointer and a small register map. The map returns a fixed identity byte, reports a permanently attached sink, and holds one control register used for a two-step bus handover.

A host first writes the control register with the request bit set. It then writes the request and grant bits together, which moves the device into DDC pass-through mode. The mode is shown to the rest of the chip on `ddc_mode_o`. Clearing the request bit drops both the pending request and the mode. The pointer advances by one after every data byte, in both directions, so a host can burst across the map.

Top module: `tx_cfg_i2c_target`

## Requirements
- R1: In a write transfer, the first byte after the address byte loads the register pointer and is not applied as a register write.
- R2: The register pointer advances by one after every data byte read and every data byte written, including bytes written to addresses that ignore them.
- R3: A read at pointer 0x1B returns 0xB0.
- R4: A read at pointer 0x3D returns 0x04; bit 0 of that byte (hot-plug event) is never set.
- R5: A write to pointer 0x1A with bit 2 (request) set raises `ddc_req_o`. If bit 1 (grant) is also set in that byte, `ddc_mode_o` rises too, and `ddc_mode_o` is never high while `ddc_req_o` is low.
- R6: A write to pointer 0x1A with bit 2 clear lowers both `ddc_req_o` and `ddc_mode_o`. Both flags change only while SCL is low.
- R7: A read at pointer 0x1A returns 0x06 while `ddc_req_o` is high and 0x00 while it is low.
- R8: Every other pointer value reads as 0x00. Writes there are acknowledged and change no flag.
- R9: After reset, `ddc_req_o`, `ddc_mode_o` and `sda_oe_o` are low and the pointer is 0x00.
- R10: The target address is the parameter `DEV_ADDR` (default 0x39). An address byte with any other address gets no ACK, the transfer has no effect, and SDA is only driven inside an addressed transfer.
- R11: The target ACKs every byte written to it. It sends read bytes MSB first, changing SDA only while SCL is low. A NACK from the controller ends the read and releases SDA, and SDA is released after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe_o | output | 1 | High to pull SDA low |
| ddc_req_o | output | 1 | Pending DDC bus request flag |
| ddc_mode_o | output | 1 | DDC pass-through mode active |

## Verification
A corrupted pointer shows up on the next read as the wrong byte. Because 0x1B and 0x3D are the only non-zero addresses apart from the control register, the bench places them at known offsets inside bursts, and a one-step pointer slip changes the very next byte read. A wrong handshake state appears on `ddc_req_o` and `ddc_mode_o` within a few system clocks of the ACK clock's falling SCL edge. It also appears one read later as the control register's value. Bit-engine faults show up within one bit time, as a missing ACK, a reversed byte or SDA still held after a NACK or STOP.

// File: rtl/tx_cfg_i2c_target.sv
module tx_cfg_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe_o,
  output logic ddc_req_o,
  output logic ddc_mode_o
);
  localparam logic [7:0] REG_CTRL  = 8'h1A;
  localparam logic [7:0] REG_ID    = 8'h1B;
  localparam logic [7:0] REG_STAT  = 8'h3D;
  localparam logic [7:0] ID_VALUE  = 8'hB0;
  localparam logic [7:0] STAT_VAL  = 8'h04;
  localparam logic [7:0] CTRL_ACK  = 8'h06;
  localparam int         REQ_BIT   = 2;
  localparam int         GNT_BIT   = 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] shr, ptr, rd_val;
  logic       addr_pend, rd_dir, mack, req, ddc, oe;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire busy      = (st != S_IDLE);

  assign sda_o      = 1'b0;
  assign sda_oe_o   = oe;
  assign ddc_req_o  = req;
  assign ddc_mode_o = ddc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end

  always_comb
    case (ptr)
      REG_CTRL: rd_val = req ? CTRL_ACK : 8'h00;
      REG_ID:   rd_val = ID_VALUE;
      REG_STAT: rd_val = STAT_VAL;
      default:  rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; shr <= '0; ptr <= '0;
      addr_pend <= 1'b0; rd_dir <= 1'b0; mack <= 1'b0;
      req <= 1'b0; ddc <= 1'b0; oe <= 1'b0;
    end else if (start_det) begin
      st <= S_ADDR; bcnt <= '0; oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WR:
          if (scl_rise) begin
            shr  <= {shr[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            if (st == S_ADDR) begin
              if (shr[7:1] == DEV_ADDR) begin
                oe <= 1'b1; st <= S_AACK; rd_dir <= shr[0];
                if (!shr[0]) addr_pend <= 1'b1;
              end else st <= S_IDLE;
            end else begin
              oe <= 1'b1; st <= S_WACK;
              if (addr_pend) begin
                ptr <= shr; addr_pend <= 1'b0;
              end else begin
                ptr <= ptr + 8'd1;
                if (ptr == REG_CTRL) begin
                  if (shr[REQ_BIT]) begin
                    req <= 1'b1;
                    if (shr[GNT_BIT]) ddc <= 1'b1;
                  end else begin
                    req <= 1'b0; ddc <= 1'b0;
                  end
                end
              end
            end
          end
        S_AACK, S_WACK:
          if (scl_fall) begin
            bcnt <= '0;
            if (st == S_AACK && rd_dir) begin
              shr <= rd_val; oe <= ~rd_val[7]; ptr <= ptr + 8'd1; st <= S_RD;
            end else begin
              oe <= 1'b0; st <= S_WR;
            end
          end
        S_RD:
          if (scl_rise) bcnt <= bcnt + 4'd1;
          else if (scl_fall) begin
            if (bcnt == 4'd8) begin
              oe <= 1'b0; st <= S_RACK;
            end else begin
              shr <= {shr[6:0], 1'b0}; oe <= ~shr[6];
            end
          end
        S_RACK:
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            bcnt <= '0;
            if (mack) begin
              shr <= rd_val; oe <= ~rd_val[7]; ptr <= ptr + 8'd1; st <= S_RD;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end
endmodule

// File: rtl/tx_cfg_i2c_target_chk.sv
module tx_cfg_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_q,
  input logic stop_det,
  input logic busy,
  input logic sda_oe,
  input logic ddc_req,
  input logic ddc_mode
);
  p_mode_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_mode |-> ddc_req);
  p_flags_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ddc_req) || !$stable(ddc_mode)) |-> !scl_s);
  p_sda_still_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |-> $stable(sda_oe));
  p_release_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  p_drive_in_session_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
endmodule

bind tx_cfg_i2c_target tx_cfg_i2c_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_sy[1]), .scl_q(scl_q),
  .stop_det(stop_det), .busy(busy), .sda_oe(sda_oe_o),
  .ddc_req(ddc_req_o), .ddc_mode(ddc_mode_o)
);

// File: tb/tx_cfg_i2c_target_tb.sv
`timescale 1ns/1ps
module tx_cfg_i2c_target_tb_top;
  localparam logic [6:0] ADDR = 7'h39;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o, sda_oe_o, ddc_req_o, ddc_mode_o;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;
  wire sda_bus = sda_m & (sda_oe_o ? sda_o : 1'b1);

  tx_cfg_i2c_target #(.DEV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe_o(sda_oe_o), .ddc_req_o(ddc_req_o), .ddc_mode_o(ddc_mode_o));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b); ack = ~b;
  endtask
  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~give_ack);
  endtask

  task automatic wr(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start; put_byte({ADDR, 1'b0}, a); chk("R11 addr ack", a, 1);
    put_byte(p, a); chk("R11 ptr ack", a, 1);
    put_byte(d, a); chk("R11 data ack", a, 1);
    bus_stop;
  endtask
  task automatic rd(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start; put_byte({ADDR, 1'b0}, a); put_byte(p, a);
    bus_start; put_byte({ADDR, 1'b1}, a); chk("R11 read addr ack", a, 1);
    get_byte(1'b0, d); bus_stop;
  endtask
  task automatic rd_cur(output logic [7:0] d);
    logic a;
    bus_start; put_byte({ADDR, 1'b1}, a); get_byte(1'b0, d); bus_stop;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic a;
    chk("R9 req after reset", ddc_req_o, 0);
    chk("R9 mode after reset", ddc_mode_o, 0);
    chk("R9 sda after reset", sda_oe_o, 0);
    bus_start; put_byte({ADDR, 1'b1}, a);
    for (int i = 0; i < 29; i++) begin
      get_byte(i != 28, d);
      chk(i == 27 ? "R9 R3 burst from ptr 0 id" : "R8 R2 burst from ptr 0", d, i == 27 ? 8'hB0 : 8'h00);
    end
    tick(2); chk("R11 released after nack", sda_oe_o, 0);
    bus_stop;
  endtask

  task automatic t_map;
    logic [7:0] d; logic a;
    rd(8'h1B, d); chk("R3 id byte", d, 8'hB0);
    rd_cur(d); chk("R2 after id", d, 8'h00);
    bus_start; put_byte({ADDR, 1'b0}, a); put_byte(8'h3C, a);
    bus_start; put_byte({ADDR, 1'b1}, a);
    get_byte(1'b1, d); chk("R8 reg 3C", d, 8'h00);
    get_byte(1'b1, d); chk("R4 status", d, 8'h04);
    get_byte(1'b0, d); chk("R8 reg 3E", d, 8'h00);
    bus_stop;
  endtask

  task automatic t_handshake;
    logic [7:0] d;
    wr(8'h1A, 8'h04);
    chk("R5 req only", {ddc_req_o, ddc_mode_o}, 8'h02);
    rd(8'h1A, d); chk("R7 ctrl with req", d, 8'h06);
    wr(8'h1A, 8'h06);
    chk("R5 grant", {ddc_req_o, ddc_mode_o}, 8'h03);
    wr(8'h1A, 8'h00);
    chk("R6 cleared", {ddc_req_o, ddc_mode_o}, 8'h00);
    rd(8'h1A, d); chk("R7 ctrl idle", d, 8'h00);
    wr(8'h1A, 8'h06);
    chk("R5 one-shot grant", {ddc_req_o, ddc_mode_o}, 8'h03);
    wr(8'h1A, 8'h02);
    chk("R6 grant without req", {ddc_req_o, ddc_mode_o}, 8'h00);
    wr(8'h1C, 8'h06);
    chk("R8 write elsewhere", {ddc_req_o, ddc_mode_o}, 8'h00);
  endtask

  task automatic t_burst_write;
    logic [7:0] d; logic a;
    bus_start; put_byte({ADDR, 1'b0}, a); put_byte(8'h18, a);
    put_byte(8'h11, a); chk("R11 ignored byte ack", a, 1);
    put_byte(8'h22, a); chk("R11 ignored byte ack", a, 1);
    put_byte(8'h06, a);
    bus_stop;
    chk("R2 pointer reached ctrl", {ddc_req_o, ddc_mode_o}, 8'h03);
    rd_cur(d); chk("R2 pointer after burst", d, 8'hB0);
  endtask

  task automatic t_first_byte;
    logic [7:0] d; logic a;
    wr(8'h19, 8'h00);
    bus_start; put_byte({ADDR, 1'b0}, a); put_byte(8'h1B, a); bus_stop;
    chk("R1 first byte not written", {ddc_req_o, ddc_mode_o}, 8'h03);
    rd_cur(d); chk("R1 pointer loaded", d, 8'hB0);
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start; put_byte({ADDR ^ 7'h03, 1'b0}, a);
    chk("R10 foreign address nack", a, 0);
    put_byte(8'h1A, a); put_byte(8'h00, a); bus_stop;
    chk("R10 foreign write ignored", {ddc_req_o, ddc_mode_o}, 8'h03);
    chk("R10 bus released", sda_oe_o, 0);
    wr(8'h1A, 8'h00);
    chk("R6 final clear", {ddc_req_o, ddc_mode_o}, 8'h00);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_map;
    t_handshake;
    t_burst_write;
    t_first_byte;
    t_wrong_addr;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule